// File: doc/BRIEF.md
# Interrupt Destination Mask Resolver

This block turns one interrupt request into the set of local interrupt agents that should receive it. The request comes from a processor's command register or from a routed I/O interrupt pin. Up to 255 agents are addressed. The result is a 256-bit recipient mask; bit 255 never corresponds to a real agent.

Each request carries the following fields:
- a destination byte
- a physical/logical addressing bit
- a two-bit shorthand code
- the sender's agent number
- a delivery mode
- the level and trigger bits

Each agent has three pieces of per-slot state, loaded through a single write port:
- a logical ID byte
- a four-bit destination format value
- a populated flag

The addressing rules are physical, logical flat and logical cluster. After those rules are applied, the delivery mode refines the result:
- Lowest-priority delivery reduces the set to its lowest-numbered member and also reports that member's index.
- An INIT request in level-deassert form delivers to nobody. Instead it reports the selected agents as the set whose arbitration IDs must be reloaded from their own IDs.

All results are registered. They appear one clock after the request strobe, together with a one-cycle done pulse, and they hold until the next request.

Top module: `irq_dest_resolver`

## Requirements
- R1: With the addressing bit at 0 (physical), destination 0xFF selects every populated agent. Any other destination value selects only the populated agent whose number equals the destination byte.
- R2: With the addressing bit at 1 (logical), an agent whose format value is 4'hF is selected when the destination byte ANDed with its logical ID is nonzero.
- R3: With the addressing bit at 1, an agent whose format value is 4'h0 is selected only when two conditions both hold: the upper nibbles of the destination and of its logical ID are equal, and their lower nibbles have at least one set bit in common.
- R4: With the addressing bit at 1, an agent whose format value is neither 4'h0 nor 4'hF is never selected.
- R5: The shorthand code behaves as follows:
  - 2'd0 applies the destination lookup (R1 to R4).
  - 2'd1 selects only the sender.
  - 2'd2 selects all agents.
  - 2'd3 selects all agents except the sender.
- R6: An agent slot that has not been written since reset never appears in `rcpt_mask` or `arb_mask`. Writes to slot 255 are ignored. Reset clears every populated flag, logical ID and format value, and drives all outputs to zero.
- R7: In lowest-priority mode (3'b001), when the selected set is non-empty:
  - `lp_valid` is 1;
  - `lp_idx` is the lowest-numbered selected agent (the first set bit of the first nonzero 32-bit word, counting from word 0);
  - `rcpt_mask` holds only that bit.

  When the selected set is empty, `lp_valid` and `rcpt_mask` are 0. In every other mode, `lp_valid` and `lp_idx` are 0.
- R8: For INIT mode (3'b101) with level 0 and trigger 1, `rcpt_mask` is 0 and `arb_mask` holds the selected set. In all other cases, `arb_mask` is 0 and `rcpt_mask` holds the selected set, except in lowest-priority mode (R7).
- R9: A request strobed at a clock edge produces its results, and `done` at 1, after that edge. `done` is 0 after an edge with no strobe, and the result outputs keep their values.
- R10: When a table write and a request occur at the same edge, the request is resolved against the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 8 | Agent slot to write |
| cfg_log_id | input | 8 | Logical ID for the slot |
| cfg_fmt | input | 4 | Destination format value for the slot |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination byte |
| req_dest_mode | input | 1 | 0 physical, 1 logical |
| req_shorthand | input | 2 | Shorthand code |
| req_sender | input | 8 | Sender's agent number |
| req_dlv_mode | input | 3 | Delivery mode (3'b001 lowest priority, 3'b101 INIT) |
| req_level | input | 1 | Level bit |
| req_trigger | input | 1 | Trigger bit |
| done | output | 1 | One-cycle result strobe |
| rcpt_mask | output | 256 | Agents that receive the interrupt |
| arb_mask | output | 256 | Agents that reload their arbitration ID |
| lp_valid | output | 1 | Lowest-priority pick is valid |
| lp_idx | output | 8 | Lowest-priority selected agent |

## Verification
A table write and a request can fall in the same cycle. The write may touch an agent that the request addresses: it can populate the agent, or change its logical ID or format. The bench provokes this both deliberately and within a long pseudo-random phase that mixes writes, requests and both together. Its behavioural model computes the expected result from the table as it stood before applying the write, and it compares every output on every clock, so a request that sees the new entry is reported.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  typedef enum logic [2:0] {
    DM_FIXED   = 3'b000,
    DM_LOWEST  = 3'b001,
    DM_SMI     = 3'b010,
    DM_NMI     = 3'b100,
    DM_INIT    = 3'b101,
    DM_STARTUP = 3'b110,
    DM_EXTINT  = 3'b111
  } dlv_mode_e;

  typedef enum logic [1:0] {
    SH_LOOKUP = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;

endpackage

// File: rtl/irq_agent_table.sv
module irq_agent_table #(
  parameter int unsigned N_AGENTS = 255,
  parameter int unsigned ID_W     = 8,
  parameter int unsigned FMT_W    = 4,
  localparam int unsigned SLOTS   = 1 << ID_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [ID_W-1:0]          widx,
  input  logic [ID_W-1:0]          wlid,
  input  logic [FMT_W-1:0]         wfmt,
  output logic [SLOTS-1:0]         pop,
  output logic [SLOTS*ID_W-1:0]    lid_flat,
  output logic [SLOTS*FMT_W-1:0]   fmt_flat
);

  // Every slot is read in parallel by the decoder, so the table lives in flops.
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < N_AGENTS) begin : g_real
      logic              pop_r;
      logic [ID_W-1:0]   lid_r;
      logic [FMT_W-1:0]  fmt_r;

      always_ff @(posedge clk) begin
        if (rst) begin
          pop_r <= 1'b0;
          lid_r <= '0;
          fmt_r <= '0;
        end else if (we && (widx == ID_W'(i))) begin
          pop_r <= 1'b1;
          lid_r <= wlid;
          fmt_r <= wfmt;
        end
      end

      assign pop[i]                      = pop_r;
      assign lid_flat[i*ID_W +: ID_W]    = lid_r;
      assign fmt_flat[i*FMT_W +: FMT_W]  = fmt_r;
    end else begin : g_absent
      assign pop[i]                      = 1'b0;
      assign lid_flat[i*ID_W +: ID_W]    = '0;
      assign fmt_flat[i*FMT_W +: FMT_W]  = '0;
    end
  end

endmodule

// File: rtl/irq_dest_decoder.sv
module irq_dest_decoder
  import irq_dest_pkg::*;
#(
  parameter int unsigned ID_W   = 8,
  parameter int unsigned FMT_W  = 4,
  localparam int unsigned SLOTS = 1 << ID_W,
  localparam int unsigned HALF  = ID_W / 2
) (
  input  logic [ID_W-1:0]         dest,
  input  logic                    dest_mode,
  input  logic [1:0]              shorthand,
  input  logic [ID_W-1:0]         sender,
  input  logic [SLOTS-1:0]        pop,
  input  logic [SLOTS*ID_W-1:0]   lid_flat,
  input  logic [SLOTS*FMT_W-1:0]  fmt_flat,
  output logic [SLOTS-1:0]        sel_mask
);

  logic dest_bcast;
  assign dest_bcast = &dest;

  for (genvar i = 0; i < SLOTS; i++) begin : g_agent
    logic [ID_W-1:0]  lid;
    logic [FMT_W-1:0] fmt;
    logic phys_hit, flat_hit, clus_hit, lookup_hit;
    logic pick;

    assign lid = lid_flat[i*ID_W +: ID_W];
    assign fmt = fmt_flat[i*FMT_W +: FMT_W];

    assign phys_hit = dest_bcast || (dest == ID_W'(i));
    assign flat_hit = (fmt == FMT_W'(FMT_FLAT)) && (|(dest & lid));
    assign clus_hit = (fmt == FMT_W'(FMT_CLUSTER))
                    && (dest[ID_W-1:HALF] == lid[ID_W-1:HALF])
                    && (|(dest[HALF-1:0] & lid[HALF-1:0]));
    assign lookup_hit = dest_mode ? (flat_hit || clus_hit) : phys_hit;

    always_comb begin
      unique case (shorthand_e'(shorthand))
        SH_LOOKUP: pick = lookup_hit;
        SH_SELF:   pick = (sender == ID_W'(i));
        SH_ALL:    pick = 1'b1;
        SH_OTHERS: pick = (sender != ID_W'(i));
        default:   pick = 1'b0;
      endcase
    end

    assign sel_mask[i] = pop[i] && pick;
  end

endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int unsigned MASK_W  = 256,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned N_WORDS = MASK_W / WORD_W,
  localparam int unsigned IDX_W   = $clog2(MASK_W),
  localparam int unsigned POS_W   = $clog2(WORD_W)
) (
  input  logic [MASK_W-1:0] mask,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);

  logic [N_WORDS-1:0] word_any;
  logic [POS_W-1:0]   word_pos [N_WORDS];

  // Per-word lowest set bit.
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word;
    assign word        = mask[w*WORD_W +: WORD_W];
    assign word_any[w] = |word;

    always_comb begin
      word_pos[w] = '0;
      for (int b = WORD_W - 1; b >= 0; b--) begin
        if (word[b]) word_pos[w] = POS_W'(b);
      end
    end
  end

  // First nonzero word, searching upward from word 0.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = N_WORDS - 1; w >= 0; w--) begin
      if (word_any[w]) begin
        found = 1'b1;
        idx   = IDX_W'(w * WORD_W) + IDX_W'(word_pos[w]);
      end
    end
  end

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int unsigned N_AGENTS = 255,
  parameter int unsigned ID_W     = 8,
  parameter int unsigned FMT_W    = 4,
  parameter int unsigned WORD_W   = 32,
  localparam int unsigned MASK_W  = 1 << ID_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [ID_W-1:0]    cfg_idx,
  input  logic [ID_W-1:0]    cfg_log_id,
  input  logic [FMT_W-1:0]   cfg_fmt,
  input  logic               req_valid,
  input  logic [ID_W-1:0]    req_dest,
  input  logic               req_dest_mode,
  input  logic [1:0]         req_shorthand,
  input  logic [ID_W-1:0]    req_sender,
  input  logic [2:0]         req_dlv_mode,
  input  logic               req_level,
  input  logic               req_trigger,
  output logic               done,
  output logic [MASK_W-1:0]  rcpt_mask,
  output logic [MASK_W-1:0]  arb_mask,
  output logic               lp_valid,
  output logic [ID_W-1:0]    lp_idx
);

  logic [MASK_W-1:0]       pop_vec;
  logic [MASK_W*ID_W-1:0]  lid_flat;
  logic [MASK_W*FMT_W-1:0] fmt_flat;
  logic [MASK_W-1:0]       sel_mask;
  logic                    fs_found;
  logic [ID_W-1:0]         fs_idx;
  logic                    init_deassert;

  irq_agent_table #(
    .N_AGENTS (N_AGENTS),
    .ID_W     (ID_W),
    .FMT_W    (FMT_W)
  ) u_table (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .widx     (cfg_idx),
    .wlid     (cfg_log_id),
    .wfmt     (cfg_fmt),
    .pop      (pop_vec),
    .lid_flat (lid_flat),
    .fmt_flat (fmt_flat)
  );

  irq_dest_decoder #(
    .ID_W  (ID_W),
    .FMT_W (FMT_W)
  ) u_decode (
    .dest      (req_dest),
    .dest_mode (req_dest_mode),
    .shorthand (req_shorthand),
    .sender    (req_sender),
    .pop       (pop_vec),
    .lid_flat  (lid_flat),
    .fmt_flat  (fmt_flat),
    .sel_mask  (sel_mask)
  );

  irq_first_set #(
    .MASK_W (MASK_W),
    .WORD_W (WORD_W)
  ) u_first (
    .mask  (sel_mask),
    .found (fs_found),
    .idx   (fs_idx)
  );

  assign init_deassert = (dlv_mode_e'(req_dlv_mode) == DM_INIT)
                       && !req_level && req_trigger;

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      rcpt_mask <= '0;
      arb_mask  <= '0;
      lp_valid  <= 1'b0;
      lp_idx    <= '0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        if (init_deassert) begin
          rcpt_mask <= '0;
          arb_mask  <= sel_mask;
          lp_valid  <= 1'b0;
          lp_idx    <= '0;
        end else if (dlv_mode_e'(req_dlv_mode) == DM_LOWEST) begin
          rcpt_mask <= fs_found ? (MASK_W'(1) << fs_idx) : '0;
          arb_mask  <= '0;
          lp_valid  <= fs_found;
          lp_idx    <= fs_found ? fs_idx : '0;
        end else begin
          rcpt_mask <= sel_mask;
          arb_mask  <= '0;
          lp_valid  <= 1'b0;
          lp_idx    <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
  parameter int unsigned ID_W   = 8,
  localparam int unsigned MASK_W = 1 << ID_W
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_shorthand,
  input logic [ID_W-1:0]   req_sender,
  input logic              done,
  input logic [MASK_W-1:0] rcpt_mask,
  input logic [MASK_W-1:0] arb_mask,
  input logic              lp_valid,
  input logic [ID_W-1:0]   lp_idx,
  input logic [MASK_W-1:0] pop_vec
);

  // R9
  done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done);

  // R9
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !done);

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(rcpt_mask) && $stable(arb_mask)));

  // R6
  unpopulated_silent_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (((rcpt_mask | arb_mask) & ~pop_vec) == '0));

  // R7
  lowest_single_chk: assert property (@(posedge clk) disable iff (rst)
    (done && lp_valid) |-> (($countones(rcpt_mask) == 1) && rcpt_mask[lp_idx]));

  // R8
  arb_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (arb_mask != '0)) |-> (rcpt_mask == '0));

  // R5
  self_only_chk: assert property (@(posedge clk) disable iff (rst)
    (done && ($past(req_shorthand) == 2'd1))
      |-> (((rcpt_mask | arb_mask) & ~(MASK_W'(1) << $past(req_sender))) == '0));

endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(.ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_shorthand (req_shorthand),
  .req_sender    (req_sender),
  .done          (done),
  .rcpt_mask     (rcpt_mask),
  .arb_mask      (arb_mask),
  .lp_valid      (lp_valid),
  .lp_idx        (lp_idx),
  .pop_vec       (pop_vec)
);

// File: tb/irq_dest_resolver_tb.sv
module irq_dest_resolver_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [7:0]   cfg_idx = '0;
  logic [7:0]   cfg_log_id = '0;
  logic [3:0]   cfg_fmt = '0;
  logic         req_valid = 1'b0;
  logic [7:0]   req_dest = '0;
  logic         req_dest_mode = 1'b0;
  logic [1:0]   req_shorthand = '0;
  logic [7:0]   req_sender = '0;
  logic [2:0]   req_dlv_mode = '0;
  logic         req_level = 1'b0;
  logic         req_trigger = 1'b0;
  logic         done;
  logic [255:0] rcpt_mask;
  logic [255:0] arb_mask;
  logic         lp_valid;
  logic [7:0]   lp_idx;

  irq_dest_resolver u_dut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_log_id(cfg_log_id), .cfg_fmt(cfg_fmt),
    .req_valid(req_valid), .req_dest(req_dest), .req_dest_mode(req_dest_mode),
    .req_shorthand(req_shorthand), .req_sender(req_sender),
    .req_dlv_mode(req_dlv_mode), .req_level(req_level), .req_trigger(req_trigger),
    .done(done), .rcpt_mask(rcpt_mask), .arb_mask(arb_mask),
    .lp_valid(lp_valid), .lp_idx(lp_idx)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  bit         m_pop [256];
  logic [7:0] m_lid [256];
  logic [3:0] m_fmt [256];

  logic         e_done = 1'b0;
  logic [255:0] e_rcpt = '0;
  logic [255:0] e_arb  = '0;
  logic         e_lpv  = 1'b0;
  logic [7:0]   e_lpi  = '0;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [255:0] resolve(input logic [7:0] d, input logic dm,
                                           input logic [1:0] sh, input logic [7:0] snd);
    logic [255:0] r = '0;
    for (int i = 0; i < 255; i++) begin
      bit hit = 0;
      if (!m_pop[i]) continue;
      case (sh)
        2'd0: begin
          if (!dm) hit = (d == 8'hFF) || (int'(d) == i);
          else if (m_fmt[i] == 4'hF) hit = ((d & m_lid[i]) != 0);
          else if (m_fmt[i] == 4'h0)
            hit = (d[7:4] == m_lid[i][7:4]) && ((d[3:0] & m_lid[i][3:0]) != 0);
        end
        2'd1: hit = (int'(snd) == i);
        2'd2: hit = 1;
        default: hit = (int'(snd) != i);
      endcase
      r[i] = hit;
    end
    return r;
  endfunction

  // Inputs are set at a falling edge; one clock later the outputs are compared.
  task automatic step(input string tag);
    if (req_valid) begin
      logic [255:0] s = resolve(req_dest, req_dest_mode, req_shorthand, req_sender);
      e_done = 1'b1; e_arb = '0; e_lpv = 1'b0; e_lpi = '0;
      if (req_dlv_mode == 3'b101 && !req_level && req_trigger) begin
        e_rcpt = '0; e_arb = s;
      end else if (req_dlv_mode == 3'b001) begin
        e_rcpt = '0;
        for (int i = 0; i < 256; i++) begin
          if (s[i]) begin e_lpv = 1'b1; e_lpi = 8'(i); e_rcpt[i] = 1'b1; break; end
        end
      end else begin
        e_rcpt = s;
      end
    end else begin
      e_done = 1'b0;
    end
    if (cfg_we && cfg_idx != 8'hFF) begin
      m_pop[cfg_idx] = 1; m_lid[cfg_idx] = cfg_log_id; m_fmt[cfg_idx] = cfg_fmt;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    req_valid = 1'b0;
    cfg_we    = 1'b0;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (done !== e_done || rcpt_mask !== e_rcpt || arb_mask !== e_arb ||
        lp_valid !== e_lpv || lp_idx !== e_lpi) begin
      fails++;
      $display("FAIL %s: actual done=%b rcpt=%h arb=%h lpv=%b lpi=%0d expected done=%b rcpt=%h arb=%h lpv=%b lpi=%0d",
               tag, done, rcpt_mask, arb_mask, lp_valid, lp_idx,
               e_done, e_rcpt, e_arb, e_lpv, e_lpi);
    end
  endtask

  task automatic set_req(input logic [7:0] d, input logic dm, input logic [1:0] sh,
                         input logic [7:0] snd, input logic [2:0] mode,
                         input logic lvl, input logic trg);
    req_valid = 1'b1; req_dest = d; req_dest_mode = dm; req_shorthand = sh;
    req_sender = snd; req_dlv_mode = mode; req_level = lvl; req_trigger = trg;
  endtask

  task automatic set_wr(input logic [7:0] idx, input logic [7:0] lid, input logic [3:0] fmt);
    cfg_we = 1'b1; cfg_idx = idx; cfg_log_id = lid; cfg_fmt = fmt;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_pop[i] = 0; m_lid[i] = '0; m_fmt[i] = '0; end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R6 reset state");

    // R6: empty table, broadcast reaches nobody
    set_req(8'hFF, 1'b0, 2'd0, 8'd0, 3'b000, 1'b1, 1'b0); step("R6 empty table");
    set_req(8'h00, 1'b0, 2'd2, 8'd0, 3'b001, 1'b1, 1'b0); step("R7 empty lowest");

    // Populate: gaps where i%7==6; format by i%4
    for (int i = 0; i < 255; i++) begin
      if (i % 7 != 6) begin
        logic [3:0] f = (i % 4 == 0) ? 4'hF : (i % 4 == 1) ? 4'h0 :
                        (i % 4 == 2) ? 4'hF : 4'h5;
        set_wr(8'(i), 8'((i * 37 + 11) & 255), f);
        step("R6 table write");
      end
    end
    set_wr(8'hFF, 8'hFF, 4'hF); step("R6 slot 255 write");
    set_req(8'hFF, 1'b0, 2'd2, 8'd0, 3'b000, 1'b1, 1'b0); step("R6 slot 255 ignored");

    // R1 physical
    set_req(8'hFF, 1'b0, 2'd0, 8'd0, 3'b000, 1'b1, 1'b0); step("R1 broadcast");
    set_req(8'd40, 1'b0, 2'd0, 8'd0, 3'b000, 1'b1, 1'b0); step("R1 unicast 40");
    set_req(8'd6,  1'b0, 2'd0, 8'd0, 3'b000, 1'b1, 1'b0); step("R1 unpopulated 6");
    set_req(8'd254,1'b0, 2'd0, 8'd0, 3'b100, 1'b1, 1'b0); step("R1 unicast 254");

    // R2 flat, R3 cluster, R4 other formats (all share the lookup)
    set_req(8'h01, 1'b1, 2'd0, 8'd0, 3'b000, 1'b1, 1'b0); step("R2 flat bit0");
    set_req(8'hA5, 1'b1, 2'd0, 8'd0, 3'b000, 1'b1, 1'b0); step("R2 R3 mixed A5");
    set_req(8'h3F, 1'b1, 2'd0, 8'd0, 3'b000, 1'b1, 1'b0); step("R3 cluster 3F");
    set_req(8'h30, 1'b1, 2'd0, 8'd0, 3'b000, 1'b1, 1'b0); step("R3 cluster no low bits");
    set_req(8'hFF, 1'b1, 2'd0, 8'd0, 3'b000, 1'b1, 1'b0); step("R4 odd formats excluded");

    // R5 shorthand
    set_req(8'h00, 1'b0, 2'd1, 8'd3,   3'b000, 1'b1, 1'b0); step("R5 self");
    set_req(8'h00, 1'b0, 2'd1, 8'd6,   3'b000, 1'b1, 1'b0); step("R5 self unpopulated");
    set_req(8'h00, 1'b1, 2'd2, 8'd9,   3'b000, 1'b1, 1'b0); step("R5 all");
    set_req(8'h00, 1'b0, 2'd3, 8'd0,   3'b000, 1'b1, 1'b0); step("R5 all but self");
    set_req(8'h00, 1'b0, 2'd3, 8'd255, 3'b000, 1'b1, 1'b0); step("R5 others sender 255");

    // R7 lowest priority
    set_req(8'hFF, 1'b0, 2'd0, 8'd0, 3'b001, 1'b1, 1'b0); step("R7 broadcast pick");
    set_req(8'h00, 1'b0, 2'd3, 8'd0, 3'b001, 1'b1, 1'b0); step("R7 others pick");
    set_req(8'd200,1'b0, 2'd0, 8'd0, 3'b001, 1'b1, 1'b0); step("R7 high word");
    set_req(8'hF0, 1'b1, 2'd0, 8'd0, 3'b001, 1'b1, 1'b0); step("R7 logical pick");
    set_req(8'd13, 1'b0, 2'd0, 8'd0, 3'b001, 1'b1, 1'b0); step("R7 none");

    // R8 INIT forms
    set_req(8'hFF, 1'b0, 2'd0, 8'd0, 3'b101, 1'b0, 1'b1); step("R8 init deassert");
    set_req(8'hFF, 1'b0, 2'd0, 8'd0, 3'b101, 1'b1, 1'b1); step("R8 init assert");
    set_req(8'hFF, 1'b0, 2'd0, 8'd0, 3'b101, 1'b0, 1'b0); step("R8 init edge");

    // R9 idle hold
    repeat (3) step("R9 idle hold");

    // R10 write and request in the same cycle
    set_wr(8'd6, 8'hFF, 4'hF);
    set_req(8'd6, 1'b0, 2'd0, 8'd0, 3'b000, 1'b1, 1'b0); step("R10 concurrent populate");
    set_req(8'd6, 1'b0, 2'd0, 8'd0, 3'b000, 1'b1, 1'b0); step("R10 after populate");
    set_wr(8'd0, 8'h00, 4'h5);
    set_req(8'h00, 1'b0, 2'd0, 8'd0, 3'b001, 1'b1, 1'b0); step("R10 concurrent reformat");

    // Mixed pseudo-random traffic
    for (int n = 0; n < 1500; n++) begin
      int unsigned r = $urandom;
      logic [2:0] modes [7] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110, 3'b111};
      logic [3:0] fmts  [4] = '{4'hF, 4'h0, 4'h5, 4'hF};
      bit w = (r[3:0] < 3);
      bit q = (r[7:4] < 12);
      if (w) set_wr(8'($urandom), 8'($urandom), fmts[$urandom % 4]);
      if (q) set_req(8'($urandom), r[8], r[10:9], 8'($urandom), modes[$urandom % 7],
                     r[11], r[12]);
      step((w && q) ? "R10 random mix" : "R9 random traffic");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule